// File: doc/BRIEF.md
# SMI and Clock-Throttle Power Manager

This block collects system management interrupt (SMI) requests from eight sources into a request register and drives an active-low SMI output whenever the gate bit is set and any request is pending. Recording a request and driving the output are separate: a request is recorded while the gate is closed and appears on the output as soon as the gate opens.

The block also runs a fast-off inactivity timer. The timer reloads on any selected system event and counts down once every `PRESCALE` clock cycles. When it reaches zero it raises an SMI request. It drives an active-low stop-clock output as well. A read of the APM command register starts clock stopping. A selected system event, or any APM command write, ends it. Optional scaling makes the stop-clock output alternate between programmed low and high times.

Software reaches the block through a flat register port: writes take effect on the clock edge and reads are combinational. The APM command register itself is decoded outside the block. Only its one-cycle read and write strobes arrive here, together with one-cycle interrupt, NMI and external-SMI pulses.

Top module: `pm_smi_throttle`

## Requirements
- R1: After reset `smi_n` and `stpclk_n` are high, and every register at addresses 0 to 6 reads 0.
- R2: Request bits use this encoding: 0 = IRQ1, 1 = IRQ3, 2 = IRQ4, 3 = IRQ8, 4 = IRQ12, 5 = timer reached zero, 6 = external SMI, 7 = APM command write. The SMI-enable register at address 1 uses the same bit order. A source pulse sets its request bit (request register, address 6) only while its enable bit is 1, whatever the gate bit holds.
- R3: Writing 1 to a bit of the request register clears that bit and leaves bits written 0 unchanged. A source event in the same cycle as the clear wins, so the bit stays set.
- R4: `smi_n` is low exactly when the gate bit (control register address 0, bit 0) is 1 and some request bit is set. Setting the gate while a request is pending drives `smi_n` low in the cycle after the write.
- R5: With the stop-clock enable bit (control bit 1) set, an `apm_rd` pulse drives `stpclk_n` low from the next cycle. With the bit clear the pulse has no effect.
- R6: An `apm_wr` pulse clears control bit 1, and `stpclk_n` is high in the next cycle.
- R7: With scaling on (control bit 2), `stpclk_n` is low for L cycles and then high for H cycles, repeating from activation. L is the value at address 4 and H the value at address 5, and a value of 0 counts as 1.
- R8: A write to the reload register (address 3) loads the timer. The timer decrements once every `PRESCALE` cycles. The decrement that reaches zero sets request bit 5 in that same edge, provided SMI-enable bit 5 is 1. After that the timer holds at zero.
- R9: While the freeze bit (control bit 3) is 1, the timer and its prescaler hold and no expiry occurs. On release, counting resumes from where it stopped.
- R10: The event-enable register (address 2) selects system events: bits 0 to 15 select IRQ0 to IRQ15, bit 16 selects NMI and bit 17 selects any recorded SMI source. Bit 2 is not writable and reads 0. A selected event reloads the timer from the reload register, restarts the prescaler and drives `stpclk_n` high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 18 | Register write data |
| reg_rdata | output | 18 | Register read data, combinational from `reg_addr` |
| irq_pulse | input | 16 | One-cycle interrupt request pulses, IRQ0 to IRQ15 |
| nmi_pulse | input | 1 | One-cycle NMI pulse |
| ext_smi_pulse | input | 1 | One-cycle external SMI pulse |
| apm_wr | input | 1 | APM command register write strobe |
| apm_rd | input | 1 | APM command register read strobe |
| smi_n | output | 1 | SMI output, active low |
| stpclk_n | output | 1 | Stop-clock output, active low |

## Verification
The properties assume that `reset` is held for at least one edge before use and that every source, APM strobe and register write is a single-cycle pulse. They also assume that only the request-register write clears request bits. The bench drives every input at the falling edge for exactly one rising edge and never issues an APM read and write together. It keeps the freeze, scaling and timer tests apart so that a timer expiry never breaks a stop-clock sequence under test. The timer is run with a small prescaler, so expiry instants fall on cycles the bench can compute and check.

// File: rtl/pm_pkg.sv
package pm_pkg;
   localparam int REG_W  = 18;   // register port data width
   localparam int AW     = 3;    // register port address width
   localparam int IRQ_N  = 16;   // interrupt request lines
   localparam int SRC_N  = 8;    // SMI sources
   localparam int CTRL_W = 4;

   typedef enum logic [AW-1:0] {
      A_CTRL   = 3'd0,
      A_SMIEN  = 3'd1,
      A_EVTEN  = 3'd2,
      A_RELOAD = 3'd3,
      A_SCLO   = 3'd4,
      A_SCHI   = 3'd5,
      A_REQ    = 3'd6
   } reg_addr_e;

   // control bits
   localparam int C_GATE   = 0;
   localparam int C_STPEN  = 1;
   localparam int C_SCALE  = 2;
   localparam int C_FREEZE = 3;

   // SMI source bits (request and enable share this order)
   localparam int S_IRQ1  = 0;
   localparam int S_IRQ3  = 1;
   localparam int S_IRQ4  = 2;
   localparam int S_IRQ8  = 3;
   localparam int S_IRQ12 = 4;
   localparam int S_TMR   = 5;
   localparam int S_EXT   = 6;
   localparam int S_APM   = 7;

   // system event enable bits
   localparam int E_NMI = 16;
   localparam int E_SMI = 17;
   localparam int E_HOLE = 2;    // cascade slot, not selectable
   localparam logic [REG_W-1:0] EVT_WMASK = ~(REG_W'(1) << E_HOLE);
endpackage

// File: rtl/pm_regs.sv
module pm_regs
   import pm_pkg::*;
#(
   parameter int TMR_W = 8,
   parameter int SCL_W = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 we,
   input  logic [AW-1:0]        addr,
   input  logic [REG_W-1:0]     wdata,
   input  logic                 apm_wr,
   input  logic [SRC_N-1:0]     req_in,
   output logic [REG_W-1:0]     rdata,
   output logic [CTRL_W-1:0]    ctrl_q,
   output logic [SRC_N-1:0]     smi_en_q,
   output logic [REG_W-1:0]     evt_en_q,
   output logic [TMR_W-1:0]     reload_q,
   output logic [SCL_W-1:0]     sc_lo_q,
   output logic [SCL_W-1:0]     sc_hi_q,
   output logic                 reload_wr,
   output logic                 req_clr_we
);
   logic wr_ctrl;

   assign wr_ctrl    = we && (addr == A_CTRL);
   assign reload_wr  = we && (addr == A_RELOAD);
   assign req_clr_we = we && (addr == A_REQ);

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q   <= '0;
         smi_en_q <= '0;
         evt_en_q <= '0;
         reload_q <= '0;
         sc_lo_q  <= '0;
         sc_hi_q  <= '0;
      end else begin
         if (wr_ctrl)
            ctrl_q <= wdata[CTRL_W-1:0];
         // an APM command write always drops the stop-clock enable
         if (apm_wr)
            ctrl_q[C_STPEN] <= 1'b0;
         if (we && (addr == A_SMIEN))
            smi_en_q <= wdata[SRC_N-1:0];
         if (we && (addr == A_EVTEN))
            evt_en_q <= wdata & EVT_WMASK;
         if (reload_wr)
            reload_q <= wdata[TMR_W-1:0];
         if (we && (addr == A_SCLO))
            sc_lo_q <= wdata[SCL_W-1:0];
         if (we && (addr == A_SCHI))
            sc_hi_q <= wdata[SCL_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_CTRL:   rdata = REG_W'(ctrl_q);
         A_SMIEN:  rdata = REG_W'(smi_en_q);
         A_EVTEN:  rdata = evt_en_q;
         A_RELOAD: rdata = REG_W'(reload_q);
         A_SCLO:   rdata = REG_W'(sc_lo_q);
         A_SCHI:   rdata = REG_W'(sc_hi_q);
         A_REQ:    rdata = REG_W'(req_in);
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/pm_smi_rec.sv
module pm_smi_rec #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] src,
   input  logic [N-1:0] en,
   input  logic         clr_we,
   input  logic [N-1:0] clr_mask,
   input  logic         gate,
   output logic [N-1:0] req,
   output logic         fired,
   output logic         smi_n
);
   logic [N-1:0] hit;

   assign hit = src & en;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst)
            req[i] <= 1'b0;
         else if (hit[i])
            req[i] <= 1'b1;
         else if (clr_we && clr_mask[i])
            req[i] <= 1'b0;
      end
   end

   assign fired = |hit;
   assign smi_n = ~(gate & (|req));
endmodule

// File: rtl/pm_fastoff.sv
module pm_fastoff #(
   parameter int TMR_W    = 8,
   parameter int PRESCALE = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             freeze,
   input  logic             reload_evt,
   input  logic [TMR_W-1:0] reload_val,
   input  logic             ld_we,
   input  logic [TMR_W-1:0] ld_val,
   output logic [TMR_W-1:0] count,
   output logic             expire
);
   localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

   logic tick;

   if (PRESCALE == 1) begin : g_nopre
      assign tick = ~freeze;
   end else begin : g_pre
      localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
         if (rst)
            pre_q <= '0;
         else if (ld_we || reload_evt)
            pre_q <= '0;
         else if (!freeze)
            pre_q <= (pre_q == PLAST) ? '0 : pre_q + 1'b1;
      end
      assign tick = ~freeze & (pre_q == PLAST);
   end

   always_ff @(posedge clk) begin
      if (rst)
         count <= '0;
      else if (ld_we)
         count <= ld_val;
      else if (reload_evt)
         count <= reload_val;
      else if (tick && (count != '0))
         count <= count - 1'b1;
   end

   assign expire = tick && (count == TMR_W'(1));
endmodule

// File: rtl/pm_stpclk.sv
module pm_stpclk #(
   parameter int SCL_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             scale_en,
   input  logic [SCL_W-1:0] lo_time,
   input  logic [SCL_W-1:0] hi_time,
   input  logic             start,
   input  logic             stop,
   output logic             active,
   output logic             stpclk_n
);
   logic             low_q;
   logic [SCL_W-1:0] cnt_q;
   logic [SCL_W-1:0] lo_len, hi_len, cur_len;

   assign lo_len  = (lo_time == '0) ? SCL_W'(1) : lo_time;
   assign hi_len  = (hi_time == '0) ? SCL_W'(1) : hi_time;
   assign cur_len = low_q ? lo_len : hi_len;

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         low_q  <= 1'b1;
         cnt_q  <= '0;
      end else if (stop || !en) begin
         active <= 1'b0;
      end else if (!active && start) begin
         active <= 1'b1;
         low_q  <= 1'b1;
         cnt_q  <= '0;
      end else if (active && scale_en) begin
         if (cnt_q == cur_len - 1'b1) begin
            low_q <= ~low_q;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign stpclk_n = ~(active & (~scale_en | low_q));
endmodule

// File: rtl/pm_smi_throttle.sv
module pm_smi_throttle
   import pm_pkg::*;
#(
   parameter int TMR_W    = 8,
   parameter int SCL_W    = 4,
   parameter int PRESCALE = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             reg_we,
   input  logic [AW-1:0]    reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic [IRQ_N-1:0] irq_pulse,
   input  logic             nmi_pulse,
   input  logic             ext_smi_pulse,
   input  logic             apm_wr,
   input  logic             apm_rd,
   output logic             smi_n,
   output logic             stpclk_n
);
   if (TMR_W < 1 || TMR_W > REG_W) begin : g_bad_tmr
      $error("TMR_W out of range");
   end
   if (SCL_W < 1 || SCL_W > REG_W) begin : g_bad_scl
      $error("SCL_W out of range");
   end
   if (PRESCALE < 1) begin : g_bad_pre
      $error("PRESCALE must be at least 1");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [SRC_N-1:0]  smi_en_q, req_q, src;
   logic [REG_W-1:0]  evt_en_q;
   logic [TMR_W-1:0]  reload_q, tmr_count;
   logic [SCL_W-1:0]  sc_lo_q, sc_hi_q;
   logic              reload_wr, req_clr_we, smi_fired, tmr_expire;
   logic              sys_evt, tmr_reload, stp_active;

   pm_regs #(.TMR_W(TMR_W), .SCL_W(SCL_W)) u_regs (
      .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .apm_wr(apm_wr), .req_in(req_q), .rdata(reg_rdata), .ctrl_q(ctrl_q),
      .smi_en_q(smi_en_q), .evt_en_q(evt_en_q), .reload_q(reload_q),
      .sc_lo_q(sc_lo_q), .sc_hi_q(sc_hi_q), .reload_wr(reload_wr),
      .req_clr_we(req_clr_we)
   );

   assign src[S_IRQ1]  = irq_pulse[1];
   assign src[S_IRQ3]  = irq_pulse[3];
   assign src[S_IRQ4]  = irq_pulse[4];
   assign src[S_IRQ8]  = irq_pulse[8];
   assign src[S_IRQ12] = irq_pulse[12];
   assign src[S_TMR]   = tmr_expire;
   assign src[S_EXT]   = ext_smi_pulse;
   assign src[S_APM]   = apm_wr;

   pm_smi_rec #(.N(SRC_N)) u_rec (
      .clk(clk), .rst(rst), .src(src), .en(smi_en_q), .clr_we(req_clr_we),
      .clr_mask(reg_wdata[SRC_N-1:0]), .gate(ctrl_q[C_GATE]), .req(req_q),
      .fired(smi_fired), .smi_n(smi_n)
   );

   assign sys_evt = (|(irq_pulse & evt_en_q[IRQ_N-1:0]))
                  | (nmi_pulse & evt_en_q[E_NMI])
                  | (smi_fired & evt_en_q[E_SMI]);
   assign tmr_reload = sys_evt | reload_wr;

   pm_fastoff #(.TMR_W(TMR_W), .PRESCALE(PRESCALE)) u_tmr (
      .clk(clk), .rst(rst), .freeze(ctrl_q[C_FREEZE]), .reload_evt(sys_evt),
      .reload_val(reload_q), .ld_we(reload_wr), .ld_val(reg_wdata[TMR_W-1:0]),
      .count(tmr_count), .expire(tmr_expire)
   );

   pm_stpclk #(.SCL_W(SCL_W)) u_stp (
      .clk(clk), .rst(rst), .en(ctrl_q[C_STPEN]), .scale_en(ctrl_q[C_SCALE]),
      .lo_time(sc_lo_q), .hi_time(sc_hi_q), .start(apm_rd),
      .stop(sys_evt | apm_wr), .active(stp_active), .stpclk_n(stpclk_n)
   );
endmodule

// File: rtl/pm_smi_throttle_chk.sv
module pm_smi_throttle_chk
   import pm_pkg::*;
#(
   parameter int TMR_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              reg_we,
   input logic [AW-1:0]     reg_addr,
   input logic              wdata0,
   input logic              apm_rd,
   input logic              apm_wr,
   input logic              smi_n,
   input logic              stpclk_n,
   input logic [CTRL_W-1:0] ctrl,
   input logic [SRC_N-1:0]  req,
   input logic              sys_evt,
   input logic              stp_active,
   input logic              tmr_reload,
   input logic [TMR_W-1:0]  count
);
   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(reg_we && reg_addr == A_REQ) |=> ((req & $past(req)) == $past(req)));

   // R4
   gate_open_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_we && reg_addr == A_CTRL && wdata0 && (|req)) |=> !smi_n);

   // R5
   stp_start_chk: assert property (@(posedge clk) disable iff (rst)
      (apm_rd && ctrl[C_STPEN] && !stp_active && !apm_wr && !sys_evt) |=> !stpclk_n);

   // R6
   apm_wr_chk: assert property (@(posedge clk) disable iff (rst)
      apm_wr |=> (stpclk_n && !ctrl[C_STPEN]));

   // R8
   tmr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (count == '0 && !tmr_reload) |=> (count == '0));

   // R9
   freeze_chk: assert property (@(posedge clk) disable iff (rst)
      (ctrl[C_FREEZE] && !tmr_reload) |=> $stable(count));

   // R10
   break_chk: assert property (@(posedge clk) disable iff (rst)
      sys_evt |=> stpclk_n);
endmodule

bind pm_smi_throttle pm_smi_throttle_chk #(.TMR_W(TMR_W)) u_chk (
   .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
   .wdata0(reg_wdata[0]), .apm_rd(apm_rd), .apm_wr(apm_wr), .smi_n(smi_n),
   .stpclk_n(stpclk_n), .ctrl(ctrl_q), .req(req_q), .sys_evt(sys_evt),
   .stp_active(stp_active), .tmr_reload(tmr_reload), .count(tmr_count)
);

// File: tb/tb_pm_smi_throttle.sv
module tb_pm_smi_throttle;
   localparam int P = 3;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [17:0] reg_wdata = '0;
   logic [17:0] reg_rdata;
   logic [15:0] irq_pulse = '0;
   logic        nmi_pulse = 1'b0, ext_smi_pulse = 1'b0;
   logic        apm_wr = 1'b0, apm_rd = 1'b0;
   logic        smi_n, stpclk_n;

   int nvec = 0;
   int nerr = 0;
   logic [17:0] v;

   pm_smi_throttle #(.TMR_W(8), .SCL_W(4), .PRESCALE(P)) dut (
      .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pulse(irq_pulse),
      .nmi_pulse(nmi_pulse), .ext_smi_pulse(ext_smi_pulse), .apm_wr(apm_wr),
      .apm_rd(apm_rd), .smi_n(smi_n), .stpclk_n(stpclk_n)
   );

   always #2 clk = ~clk;

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: got %0h expected %0h", r, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [17:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [17:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   // SMI source encoding: 0 IRQ1,1 IRQ3,2 IRQ4,3 IRQ8,4 IRQ12,6 ext,7 APM write
   task automatic pulse_src(input int s);
      @(negedge clk);
      case (s)
         0: irq_pulse[1] = 1'b1;
         1: irq_pulse[3] = 1'b1;
         2: irq_pulse[4] = 1'b1;
         3: irq_pulse[8] = 1'b1;
         4: irq_pulse[12] = 1'b1;
         6: ext_smi_pulse = 1'b1;
         default: apm_wr = 1'b1;
      endcase
      @(negedge clk);
      irq_pulse = '0; ext_smi_pulse = 1'b0; apm_wr = 1'b0;
   endtask

   task automatic pulse_irq(input int n);
      @(negedge clk);
      irq_pulse[n] = 1'b1;
      @(negedge clk);
      irq_pulse = '0;
   endtask

   task automatic pulse_apm_rd();
      @(negedge clk);
      apm_rd = 1'b1;
      @(negedge clk);
      apm_rd = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 7; a++) begin
         rd(3'(a), v);
         chk("R1 reg", 32'(v), 32'h0);
      end
      chk("R1 smi_n", 32'(smi_n), 32'h1);
      chk("R1 stpclk_n", 32'(stpclk_n), 32'h1);

      // R2 / R3 sweep over sources, gate closed
      for (int s = 0; s < 8; s++) begin
         if (s == 5) continue;
         wr(3'd1, 18'(1 << s));
         pulse_src(s);
         rd(3'd6, v);
         chk("R2 recorded", 32'(v), 32'(1 << s));
         chk("R4 gate closed", 32'(smi_n), 32'h1);
         wr(3'd1, 18'h0);
         wr(3'd6, 18'hFF);
         rd(3'd6, v);
         chk("R3 cleared", 32'(v), 32'h0);
         pulse_src(s);
         rd(3'd6, v);
         chk("R2 disabled source", 32'(v), 32'h0);
      end

      // R3 partial clear
      wr(3'd1, 18'h41);
      pulse_src(0);
      pulse_src(6);
      wr(3'd6, 18'h40);
      rd(3'd6, v);
      chk("R3 partial clear", 32'(v), 32'h01);

      // R4 gate opens with pending request
      wr(3'd0, 18'h1);
      chk("R4 open with pending", 32'(smi_n), 32'h0);
      wr(3'd6, 18'h01);
      chk("R4 none pending", 32'(smi_n), 32'h1);
      pulse_src(6);
      chk("R4 new request", 32'(smi_n), 32'h0);

      // R3 set wins over clear
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 18'h40; ext_smi_pulse = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0; ext_smi_pulse = 1'b0;
      rd(3'd6, v);
      chk("R3 set wins", 32'(v), 32'h40);
      wr(3'd6, 18'hFF);
      wr(3'd1, 18'h0);
      wr(3'd0, 18'h0);

      // R5 stop-clock start
      pulse_apm_rd();
      chk("R5 disabled read", 32'(stpclk_n), 32'h1);
      wr(3'd0, 18'h2);
      pulse_apm_rd();
      chk("R5 asserted", 32'(stpclk_n), 32'h0);
      repeat (5) @(negedge clk);
      chk("R5 held", 32'(stpclk_n), 32'h0);

      // R6 APM write
      pulse_src(7);
      chk("R6 negated", 32'(stpclk_n), 32'h1);
      rd(3'd0, v);
      chk("R6 enable cleared", 32'(v), 32'h0);

      // R7 scaling sweep
      for (int lo = 0; lo < 4; lo++) begin
         for (int hi = 0; hi < 3; hi++) begin
            int el, eh;
            el = (lo == 0) ? 1 : lo;
            eh = (hi == 0) ? 1 : hi;
            wr(3'd4, 18'(lo));
            wr(3'd5, 18'(hi));
            wr(3'd0, 18'h6);
            pulse_apm_rd();
            for (int t = 0; t < 12; t++) begin
               chk("R7 scaled phase", 32'(stpclk_n), ((t % (el + eh)) < el) ? 32'h0 : 32'h1);
               @(negedge clk);
            end
            pulse_src(7);
         end
      end

      // R10 break and unselectable IRQ2
      wr(3'd0, 18'h2);
      wr(3'd2, 18'h3FFFF);
      rd(3'd2, v);
      chk("R10 slot 2 reads 0", 32'(v), 32'h3FFFB);
      pulse_apm_rd();
      chk("R10 active", 32'(stpclk_n), 32'h0);
      pulse_irq(2);
      chk("R10 irq2 ignored", 32'(stpclk_n), 32'h0);
      pulse_irq(5);
      chk("R10 break", 32'(stpclk_n), 32'h1);
      pulse_apm_rd();
      @(negedge clk);
      nmi_pulse = 1'b1;
      @(negedge clk);
      nmi_pulse = 1'b0;
      chk("R10 nmi break", 32'(stpclk_n), 32'h1);
      wr(3'd2, 18'h0);
      wr(3'd0, 18'h0);

      // R8 timer expiry timing
      wr(3'd1, 18'h20);
      for (int n = 1; n < 4; n++) begin
         wr(3'd3, 18'(n));
         repeat (n * P - 1) @(negedge clk);
         rd(3'd6, v);
         chk("R8 before expiry", 32'(v), 32'h0);
         @(negedge clk);
         rd(3'd6, v);
         chk("R8 at expiry", 32'(v), 32'h20);
         wr(3'd6, 18'hFF);
         repeat (4 * P) @(negedge clk);
         rd(3'd6, v);
         chk("R8 holds at zero", 32'(v), 32'h0);
      end

      // R9 freeze
      wr(3'd0, 18'h8);
      wr(3'd3, 18'h2);
      repeat (20) @(negedge clk);
      rd(3'd6, v);
      chk("R9 frozen", 32'(v), 32'h0);
      wr(3'd0, 18'h0);
      repeat (2 * P - 1) @(negedge clk);
      rd(3'd6, v);
      chk("R9 resumed early", 32'(v), 32'h0);
      @(negedge clk);
      rd(3'd6, v);
      chk("R9 resumed expiry", 32'(v), 32'h20);
      wr(3'd6, 18'hFF);

      // R10 event reloads the timer
      wr(3'd2, 18'h20);
      wr(3'd3, 18'h3);
      repeat (4) @(negedge clk);
      pulse_irq(5);
      repeat (3 * P - 1) @(negedge clk);
      rd(3'd6, v);
      chk("R10 reload delays expiry", 32'(v), 32'h0);
      @(negedge clk);
      rd(3'd6, v);
      chk("R10 expiry after reload", 32'(v), 32'h20);

      finish_run();
   end
endmodule